// File: doc/BRIEF.md
# Commutation Advance Timing Scheduler

This block decides when a six-step brushless motor drive should switch to its next state. It counts time-base ticks between successive estimated back-EMF zero-cross strobes and takes half of the latest interval as the nominal commutation delay. It then issues a single-cycle commutate pulse earlier than that nominal point by an advance time. The pulse never comes later than the nominal point.

The advance setting is a 7-bit word. A 3-bit exponent shifts a 4-bit mantissa left, and each count is one tick, nominally 2.5 µs. In the fixed mode the advance equals this setting. In the scaled mode the setting is multiplied by (U − BEMF)/U, where U is the phase-voltage amplitude and BEMF is the back-EMF amplitude. A sequential divider computes this quotient and finishes long before the first tick that can fire. All configuration inputs are captured at each zero-cross strobe.

Top module: `comm_adv_sched`

## Requirements
- R1: After reset `commOut` is low. No commutate pulse appears until at least two zero-cross strobes have been accepted.
- R2: The configuration word holds the mantissa in bits [3:0] and the shift exponent in bits [6:4]. The setting in ticks is mantissa << exponent. With `advMode` = 0 the advance equals the setting, so 0x13 gives 6 ticks and 0x7F gives 1920 ticks.
- R3: The stored interval is the number of ticks seen since the previous strobe, and a tick in the same cycle as the strobe counts toward the interval that is ending. The pulse is due at the tick whose count since the strobe reaches floor(interval/2) − advance. `commOut` goes high in the clock cycle after that tick.
- R4: When the advance is greater than or equal to floor(interval/2), the pulse follows the first tick after the strobe.
- R5: With `advMode` = 1 and U > BEMF, the advance is floor(setting × (U − BEMF) / U).
- R6: With `advMode` = 1, the advance is zero when BEMF ≥ U or U = 0.
- R7: The configuration word, mode and amplitudes are sampled only at a zero-cross strobe. Changes made between strobes have no effect on the pending pulse.
- R8: A strobe that arrives before the pending pulse has fired cancels it, including a strobe in the same cycle as the tick that would fire. Interval counting restarts from that strobe.
- R9: At most one pulse is issued per interval, and each pulse lasts exactly one clock cycle. Pulses are only issued after a tick, given that the first tick after a strobe is at least 21 clock cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| zcStrobe | input | 1 | One-cycle estimated back-EMF zero-cross strobe |
| tickEn | input | 1 | Time-base tick enable, one pulse per 2.5 µs |
| advCfg | input | 7 | Advance setting: exponent [6:4], mantissa [3:0] |
| advMode | input | 1 | 0 fixed advance, 1 amplitude-scaled advance |
| uAmp | input | 8 | Unsigned phase-voltage amplitude |
| bemfAmp | input | 8 | Unsigned back-EMF amplitude |
| commOut | output | 1 | One-cycle commutate pulse |

## Verification
Two events can land in the same cycle: a zero-cross strobe and the tick that would fire the pending pulse. The bench provokes this by shortening an interval to exactly the firing tick count, so that the strobe arrives together with that tick. It expects no pulse from the cancelled interval. In the following interval it expects a pulse at half of the shortened length. A behavioural model, which does not use a divider, predicts `commOut` on every clock. Directed counts of pulses and their tick positions then judge the fixed, scaled, clamped and cancelled cases.

// File: rtl/cas_pkg.sv
package cas_pkg;

  // Strobes handed from the control to the datapath
  typedef struct packed {
    logic load;     // zero cross accepted: capture interval and settings
    logic divInit;  // start the scaled-advance division
    logic divStep;  // one restoring-division step
    logic advLoad;  // copy the quotient into the advance register
  } casStrobe_t;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_DIV   = 2'd1,
    PH_FIN   = 2'd2,
    PH_READY = 2'd3
  } casPhase_t;

endpackage

// File: rtl/cas_dp.sv
module cas_dp
  import cas_pkg::*;
#(
  parameter int VAL_W = 4,
  parameter int SHF_W = 3,
  parameter int AMP_W = 8,
  parameter int CNT_W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  casStrobe_t             stb,
  input  logic                   tickEn,
  input  logic                   advMode,
  input  logic [VAL_W+SHF_W-1:0] advCfg,
  input  logic [AMP_W-1:0]       uAmp,
  input  logic [AMP_W-1:0]       bemfAmp,
  output logic                   needDiv,
  output logic                   hitTarget
);
  localparam int CFG_W = VAL_W + SHF_W;
  localparam int SET_W = VAL_W + (1 << SHF_W) - 1;
  localparam int NUM_W = SET_W + AMP_W;
  localparam int CMP_W = ((CNT_W > SET_W) ? CNT_W : SET_W) + 2;

  logic [VAL_W-1:0] cfgVal;
  logic [SHF_W-1:0] cfgShf;
  logic [SET_W-1:0] setting;
  logic [AMP_W-1:0] ampDiff;
  logic [NUM_W-1:0] product;

  logic [CNT_W-1:0] intCnt, intervalQ, intCntNext;
  logic [AMP_W-1:0] uQ;
  logic [SET_W-1:0] advQ;
  logic [AMP_W:0]   remQ, remShift, remNext;
  logic [NUM_W-1:0] quoQ, quoNext;
  logic             remGeq;

  assign cfgVal  = advCfg[VAL_W-1:0];
  assign cfgShf  = advCfg[CFG_W-1:VAL_W];
  assign setting = SET_W'(cfgVal) << cfgShf;
  assign ampDiff = uAmp - bemfAmp;
  assign product = NUM_W'(setting) * NUM_W'(ampDiff);
  assign needDiv = advMode & (uAmp > bemfAmp);

  // Interval counter saturates at all ones
  assign intCntNext = (tickEn && !(&intCnt)) ? intCnt + 1'b1 : intCnt;

  // One restoring-division step
  assign remShift = {remQ[AMP_W-1:0], quoQ[NUM_W-1]};
  assign remGeq   = remShift >= {1'b0, uQ};
  assign remNext  = remGeq ? remShift - {1'b0, uQ} : remShift;
  assign quoNext  = {quoQ[NUM_W-2:0], remGeq};

  // Fire when ticks-so-far plus advance reaches the nominal half interval;
  // ticks-so-far is at least one, so an oversized advance fires at once.
  logic [CMP_W-1:0] nomExt, advExt, nextExt;
  assign nomExt    = CMP_W'(intervalQ >> 1);
  assign advExt    = CMP_W'(advQ);
  assign nextExt   = CMP_W'(intCnt) + 1'b1;
  assign hitTarget = (nextExt + advExt) >= nomExt;

  always_ff @(posedge clk) begin
    if (rst) begin
      intCnt    <= '0;
      intervalQ <= '0;
      uQ        <= '0;
      advQ      <= '0;
      remQ      <= '0;
      quoQ      <= '0;
    end else begin
      if (stb.load) begin
        intervalQ <= intCntNext;
        intCnt    <= '0;
        uQ        <= uAmp;
        remQ      <= '0;
        quoQ      <= product;
        advQ      <= (advMode || stb.divInit) ? '0 : setting;
      end else begin
        intCnt <= intCntNext;
        if (stb.divStep) begin
          remQ <= remNext;
          quoQ <= quoNext;
        end
        if (stb.advLoad) advQ <= quoQ[SET_W-1:0];
      end
    end
  end
endmodule

// File: rtl/cas_ctrl.sv
module cas_ctrl
  import cas_pkg::*;
#(
  parameter int NUM_W = 19
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       zcStrobe,
  input  logic       tickEn,
  input  logic       needDiv,
  input  logic       hitTarget,
  output casStrobe_t stb,
  output logic       commOut
);
  localparam int DC_W = $clog2(NUM_W + 1);

  casPhase_t       phase;
  logic [DC_W-1:0] divCnt;
  logic [1:0]      zcSeen;
  logic            armed, fired, fireNow;

  always_comb begin
    stb         = '0;
    stb.load    = zcStrobe;
    stb.divInit = zcStrobe & needDiv;
    stb.divStep = (phase == PH_DIV) & ~zcStrobe;
    stb.advLoad = (phase == PH_FIN) & ~zcStrobe;
  end

  assign fireNow = (phase == PH_READY) & armed & ~fired & tickEn & ~zcStrobe & hitTarget;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      divCnt  <= '0;
      zcSeen  <= '0;
      armed   <= 1'b0;
      fired   <= 1'b0;
      commOut <= 1'b0;
    end else begin
      commOut <= fireNow;
      if (zcStrobe) begin
        zcSeen <= (zcSeen == 2'd2) ? 2'd2 : zcSeen + 2'd1;
        armed  <= (zcSeen != 2'd0);
        fired  <= 1'b0;
        divCnt <= '0;
        phase  <= needDiv ? PH_DIV : PH_READY;
      end else begin
        unique case (phase)
          PH_DIV: begin
            divCnt <= divCnt + 1'b1;
            if (divCnt == DC_W'(NUM_W - 1)) phase <= PH_FIN;
          end
          PH_FIN:   phase <= PH_READY;
          PH_READY: if (fireNow) fired <= 1'b1;
          default:  phase <= phase;
        endcase
      end
    end
  end
endmodule

// File: rtl/comm_adv_sched.sv
module comm_adv_sched
  import cas_pkg::*;
#(
  parameter int VAL_W = 4,
  parameter int SHF_W = 3,
  parameter int AMP_W = 8,
  parameter int CNT_W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   zcStrobe,
  input  logic                   tickEn,
  input  logic [VAL_W+SHF_W-1:0] advCfg,
  input  logic                   advMode,
  input  logic [AMP_W-1:0]       uAmp,
  input  logic [AMP_W-1:0]       bemfAmp,
  output logic                   commOut
);
  localparam int SET_W = VAL_W + (1 << SHF_W) - 1;
  localparam int NUM_W = SET_W + AMP_W;

  casStrobe_t stb;
  logic       needDiv, hitTarget;

  cas_ctrl #(.NUM_W(NUM_W)) u_ctrl (
    .clk(clk), .rst(rst), .zcStrobe(zcStrobe), .tickEn(tickEn),
    .needDiv(needDiv), .hitTarget(hitTarget), .stb(stb), .commOut(commOut)
  );

  cas_dp #(.VAL_W(VAL_W), .SHF_W(SHF_W), .AMP_W(AMP_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst(rst), .stb(stb), .tickEn(tickEn), .advMode(advMode),
    .advCfg(advCfg), .uAmp(uAmp), .bemfAmp(bemfAmp),
    .needDiv(needDiv), .hitTarget(hitTarget)
  );
endmodule

// File: rtl/cas_chk.sv
module cas_chk (
  input logic clk,
  input logic rst,
  input logic zcStrobe,
  input logic tickEn,
  input logic commOut
);
  logic [1:0] chkZc;
  always_ff @(posedge clk) begin
    if (rst) chkZc <= '0;
    else if (zcStrobe && chkZc != 2'd2) chkZc <= chkZc + 2'd1;
  end

  // R1
  no_early_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (chkZc < 2'd2) |-> !commOut);

  // R9
  single_cycle_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    commOut |=> !commOut);

  // R3
  pulse_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
    commOut |-> $past(tickEn));

  // R8
  strobe_cancels_chk: assert property (@(posedge clk) disable iff (rst)
    commOut |-> !$past(zcStrobe));
endmodule

bind comm_adv_sched cas_chk u_cas_chk (
  .clk(clk), .rst(rst), .zcStrobe(zcStrobe), .tickEn(tickEn), .commOut(commOut)
);

// File: tb/tb_comm_adv_sched.sv
module tb_comm_adv_sched;
  localparam int TICKP = 32;
  localparam int MAXC  = 65535;

  logic       clk = 1'b0, rst = 1'b1;
  logic       zcStrobe = 1'b0, tickEn = 1'b0, advMode = 1'b0;
  logic [6:0] advCfg = '0;
  logic [7:0] uAmp = '0, bemfAmp = '0;
  logic       commOut;

  always #4 clk = ~clk;

  comm_adv_sched dut (
    .clk(clk), .rst(rst), .zcStrobe(zcStrobe), .tickEn(tickEn), .advCfg(advCfg),
    .advMode(advMode), .uAmp(uAmp), .bemfAmp(bemfAmp), .commOut(commOut)
  );

  int    checks = 0, errors = 0;
  string curReq = "R1";
  int    mCnt, mInt, mZc, mAdv, pulseCnt, pulseTick;
  bit    mFired, mArmed, expComm, done;

  task automatic chk(bit ok, string req, int act, int exp, string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int modelAdv(int cfg, bit m, int u, int b);
    int s;
    s = (cfg & 15) << ((cfg >> 4) & 7);
    if (!m) return s;
    if (b >= u || u == 0) return 0;
    return s * (u - b) / u;
  endfunction

  // Behavioural reference: predicts commOut for the cycle after each edge
  always @(posedge clk) begin
    int nom, tgt;
    if (rst) begin
      mCnt = 0; mInt = 0; mZc = 0; mAdv = 0; mFired = 0; mArmed = 0; expComm = 0;
    end else begin
      expComm = 0;
      if (zcStrobe) begin
        mInt = (tickEn && mCnt < MAXC) ? mCnt + 1 : mCnt;
        mCnt = 0;
        if (mZc < 2) mZc++;
        mArmed = (mZc >= 2);
        mFired = 0;
        mAdv = modelAdv(advCfg, advMode, uAmp, bemfAmp);
      end else if (tickEn) begin
        nom = mInt / 2;
        tgt = (mAdv >= nom) ? 1 : nom - mAdv;
        if (mCnt < MAXC) mCnt++;
        if (mArmed && !mFired && mCnt >= tgt) begin
          expComm = 1; mFired = 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(commOut === expComm, curReq, int'(commOut), int'(expComm), "commOut vs model");
      if (commOut) begin pulseCnt++; pulseTick = mCnt; end
    end
  end

  task automatic step(bit zc);
    @(negedge clk); tickEn = 1'b1; zcStrobe = zc;
    @(negedge clk); tickEn = 1'b0; zcStrobe = 1'b0;
    repeat (TICKP - 2) @(negedge clk);
  endtask

  // Strobe, then n-1 further tick periods; judge the pulses of this interval
  task automatic run(int n, string req, int expCnt, int expTick,
                     int chgAt = -1, logic [6:0] chgCfg = '0);
    curReq = req;
    pulseCnt = 0;
    step(1'b1);
    for (int i = 1; i < n; i++) begin
      if (i == chgAt) advCfg = chgCfg;
      step(1'b0);
    end
    chk(pulseCnt == expCnt, req, pulseCnt, expCnt, "pulse count");
    if (expCnt == 1) chk(pulseTick == expTick, req, pulseTick, expTick, "pulse tick");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(commOut == 1'b0, "R1", int'(commOut), 0, "reset value");
    rst = 1'b0;
    run(20, "R1", 0, 0);                        // first strobe: no pulse
    run(20, "R3", 1, 10);                       // zero advance, half of 20
    advCfg = 7'h13; run(20, "R2", 1, 4);        // 3<<1 = 6 ticks
    advCfg = 7'h7F; run(20, "R4", 1, 1);        // 1920 ticks clamps
    advMode = 1'b1; advCfg = 7'h08; uAmp = 8'd200; bemfAmp = 8'd100;
    run(20, "R5", 1, 6);                        // 8*100/200 = 4
    advCfg = 7'h2F; uAmp = 8'd240; bemfAmp = 8'd200;
    run(20, "R4", 1, 1);                        // 60*40/240 = 10 equals nominal
    bemfAmp = 8'd206; run(20, "R5", 1, 2);      // floor(60*34/240) = 8
    uAmp = 8'd100; bemfAmp = 8'd150; run(20, "R6", 1, 10);
    uAmp = 8'd0; bemfAmp = 8'd0; run(20, "R6", 1, 10);
    advMode = 1'b0; advCfg = 7'h00;
    run(20, "R7", 1, 10, 2, 7'h7F);             // mid-interval change ignored
    run(10, "R7", 1, 1);                        // change now taken
    advCfg = 7'h00;
    run(5, "R8", 0, 0);                         // strobe meets the firing tick
    run(20, "R8", 1, 2);                        // interval 5 -> nominal 2
    run(3, "R8", 0, 0);                         // early strobe cancels
    run(20, "R9", 1, 1);                        // interval 3 -> nominal 1
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule